// File: doc/BRIEF.md
# Security Event Rate Throttle

This block keeps a running score of security-relevant activity and uses it to slow down a command engine. Two kinds of activity raise the score: a failed decryption or integrity check, reported as a one-cycle pulse, and the use of a private key held inside the device. Key use is requested by the command engine and granted by this block. Every full period without a counted event lowers the score by one, down to zero. A pulse that flags suspect system behaviour drives the score straight to its ceiling.

Key-use grants are limited to one per period. The period restarts at every counted event. A request that comes too early is held off with a stall signal until the period has run out. A busy flag stays high while the score is nonzero, so that a sleep controller can wait for the decay to finish before powering down. The period is a cycle count, set to five seconds of the device clock. The ±5% tolerance on that period is covered by the choice of that count.

Top module: `sec_rate_throttle`

## Requirements
- R1: After reset the score is 0, the busy flag is low, and a key request in the first cycle is granted at once.
- R2: After a grant, further key requests are stalled for PERIOD_CYC-1 cycles. A request held continuously is granted again exactly PERIOD_CYC cycles after the previous grant.
- R3: `stall` is high exactly when `key_req` is high and `key_go` is low. `key_go` is never high without `key_req`.
- R4: A failure pulse adds 1 and a grant adds 1; both in the same cycle add 2. The score saturates at 2^CNT_W-1 and never wraps.
- R5: Each run of PERIOD_CYC cycles with no counted event lowers the score by 1, and the score stays at 0 once there. A counted event restarts the period, with its own cycle taken as the first of the new period.
- R6: A suspect pulse sets the score to 2^CNT_W-1 on the next edge. It overrides any increment in the same cycle, and it restarts the period, so following requests stall.
- R7: `idle_busy` is high exactly when the score is nonzero.
- R8: Under 500 back-to-back key requests, every gap between grants is exactly PERIOD_CYC cycles, and the score never rises above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_pulse | input | 1 | Decryption or integrity-check failure, one cycle |
| suspect_pulse | input | 1 | Suspect system behaviour, one cycle |
| key_req | input | 1 | Command engine asks to use a device-held private key |
| key_go | output | 1 | Key use granted this cycle |
| stall | output | 1 | Request held off until the period expires |
| sec_count | output | CNT_W | Current score |
| idle_busy | output | 1 | Score decay still pending |

## Verification
The bench aims at the edges of the period window. A design whose grant comes one cycle late or early would show gaps of PERIOD_CYC±1 during the 500-request run, and a miscounted decay would drop the score one edge off. Saturation is tested by adding 2 at one below the ceiling and by adding 1 at the ceiling; a design that wraps would show a small score there. A suspect pulse is sent together with a failure and a grant, to catch an increment that wins over the forced maximum. Idling with a zero score checks that the decay stops at zero and does not underflow to the maximum.

// File: rtl/sec_rate_throttle.sv
module sec_rate_throttle #(
  parameter int CNT_W      = 8,
  parameter int PERIOD_CYC = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_pulse,
  input  logic             suspect_pulse,
  input  logic             key_req,
  output logic             key_go,
  output logic             stall,
  output logic [CNT_W-1:0] sec_count,
  output logic             idle_busy
);
  localparam int TW = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] SEC_MAX = {CNT_W{1'b1}};
  localparam logic [TW-1:0] T_LAST = TW'(PERIOD_CYC - 1);

  logic [TW-1:0]  tmr;
  logic           open_q;
  logic [CNT_W-1:0] sec_q;
  logic [CNT_W:0]   sum;
  logic           evt, wrap;

  assign key_go    = key_req & (open_q | (sec_q == '0));
  assign stall     = key_req & ~key_go;
  assign evt       = fail_pulse | key_go | suspect_pulse;
  assign wrap      = ~evt & (tmr == T_LAST);
  assign sum       = {1'b0, sec_q} + (CNT_W+1)'(fail_pulse) + (CNT_W+1)'(key_go);
  assign sec_count = sec_q;
  assign idle_busy = |sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr    <= '0;
      open_q <= 1'b1;
    end else if (evt) begin
      tmr    <= TW'(1);
      open_q <= 1'b0;
    end else if (wrap) begin
      tmr    <= '0;
      open_q <= 1'b1;
    end else begin
      tmr    <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sec_q <= '0;
    else if (suspect_pulse)
      sec_q <= SEC_MAX;
    else if (evt)
      sec_q <= sum[CNT_W] ? SEC_MAX : sum[CNT_W-1:0];
    else if (wrap && sec_q != '0)
      sec_q <= sec_q - 1'b1;
  end
endmodule

// File: rtl/sec_rate_throttle_chk.sv
module sec_rate_throttle_chk #(
  parameter int CNT_W      = 8,
  parameter int PERIOD_CYC = 1_000_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fail_pulse,
  input logic             suspect_pulse,
  input logic             key_req,
  input logic             key_go,
  input logic             stall,
  input logic [CNT_W-1:0] sec_count,
  input logic             idle_busy
);
  localparam int TW = $clog2(PERIOD_CYC + 1);
  localparam logic [TW-1:0] T_FULL = TW'(PERIOD_CYC);

  logic [TW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= T_FULL;
    else if (key_go) gap <= TW'(1);
    else if (gap < T_FULL) gap <= gap + 1'b1;
  end

  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_go |-> gap >= T_FULL);

  p_go_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_go |-> key_req);

  p_req_resolved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |-> $onehot({key_go, stall}));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse || key_go) && !suspect_pulse |=> sec_count >= $past(sec_count) && sec_count != '0);

  p_decay_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_pulse && !key_go && !suspect_pulse |=>
      (sec_count == $past(sec_count)) || (sec_count == $past(sec_count) - 1'b1));

  p_suspect_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspect_pulse |=> sec_count == {CNT_W{1'b1}});

  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_busy) |-> $past(sec_count) == 1);
endmodule

bind sec_rate_throttle sec_rate_throttle_chk #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) u_chk (.*);

// File: tb/sec_rate_throttle_tb.sv
`timescale 1ns/1ps
module sec_rate_throttle_tb;
  localparam int P = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_pulse = 1'b0, suspect_pulse = 1'b0, key_req = 1'b0;
  logic key_go, stall, idle_busy;
  logic [W-1:0] sec_count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sec_rate_throttle #(.CNT_W(W), .PERIOD_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .fail_pulse(fail_pulse), .suspect_pulse(suspect_pulse),
    .key_req(key_req), .key_go(key_go), .stall(stall), .sec_count(sec_count), .idle_busy(idle_busy));

  // {fail, suspect, req, expected grant, expected score after the edge}
  localparam logic [11:0] VEC [15] = '{
    12'h301, 12'h201, 12'h201, 12'h200, 12'h301,
    12'h802, 12'h002, 12'h002, 12'h001, 12'hB03,
    12'h4FF, 12'h2FF, 12'h2FF, 12'h2FE, 12'h3FF };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fail_pulse = 0; suspect_pulse = 0; key_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: inputs at negedge, grant checked before edge, score after edge
  task automatic step(input logic f, input logic s, input logic r);
    @(negedge clk);
    fail_pulse = f; suspect_pulse = s; key_req = r;
    #1;
  endtask

  task automatic post_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int grants, last, max_sec;
    do_reset();
    chk("R1 score after reset", sec_count, 0);
    chk("R1 busy after reset", idle_busy, 0);

    for (int i = 0; i < 15; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9]);
      chk($sformatf("R2 grant step %0d", i), key_go, VEC[i][8]);
      chk($sformatf("R3 stall step %0d", i), stall, VEC[i][9] & ~VEC[i][8]);
      post_edge();
      chk($sformatf("R4 R5 R6 score step %0d", i), sec_count, VEC[i][7:0]);
      chk($sformatf("R7 busy step %0d", i), idle_busy, VEC[i][7:0] != 0);
    end

    // R5: decay timing after a failure, then floor at zero
    do_reset();
    step(1, 0, 0); post_edge();
    chk("R4 single failure", sec_count, 1);
    for (int k = 0; k < P - 2; k++) begin step(0, 0, 0); post_edge(); end
    chk("R5 no early decay", sec_count, 1);
    step(0, 0, 0); post_edge();
    chk("R5 decay after full period", sec_count, 0);
    chk("R7 busy low at zero", idle_busy, 0);
    for (int k = 0; k < 3 * P; k++) begin step(0, 0, 0); post_edge(); end
    chk("R5 floor at zero", sec_count, 0);

    // R6 override, R4 saturation
    do_reset();
    step(1, 1, 1);
    chk("R1 first request granted", key_go, 1);
    post_edge();
    chk("R6 suspect overrides increments", sec_count, 255);
    step(0, 0, 1);
    chk("R6 request stalls after suspect", stall, 1);
    post_edge();
    for (int k = 0; k < P - 2; k++) begin step(0, 0, 0); post_edge(); end
    chk("R5 decay from max", sec_count, 254);
    step(1, 0, 1);
    chk("R2 grant after period", key_go, 1);
    post_edge();
    chk("R4 saturate on +2", sec_count, 255);
    step(1, 0, 0); post_edge();
    chk("R4 hold at max", sec_count, 255);

    // R8: 500 back-to-back requests
    do_reset();
    grants = 0; last = -1; max_sec = 0;
    for (int c = 0; c < 500 * P; c++) begin
      step(0, 0, 1);
      if (key_go) begin
        if (last >= 0 && c - last != P)
          chk("R8 grant gap", c - last, P);
        grants++;
        last = c;
      end
      post_edge();
      if (sec_count > max_sec) max_sec = sec_count;
    end
    chk("R8 grant count", grants, 500);
    chk("R8 score bound", max_sec, 1);

    step(0, 0, 0);
    finish_run();
  end
endmodule